// File: doc/BRIEF.md
# Vector SHA-2 Sigma Unit

This block computes the SHA-2 sigma functions across a 128-bit vector in a single registered stage. It has two size modes. In the narrow mode it treats the vector as four 32-bit words, which serves SHA-256. In the wide mode it treats the vector as two 64-bit words, which serves SHA-512. A 5-bit control field goes with every request. Its high bit picks one of two families: the message-expansion sigmas (lowercase) or the round-compression sigmas (uppercase). Its low four bits form a mask, and the mask picks sigma0 or sigma1 separately for each lane. One vector can therefore carry a mix of sigma0 and sigma1 results.

Requests and results both use valid/ready handshakes. The unit accepts one request per cycle, and the result appears in the output register on the following cycle. When the downstream side holds `out_ready` low, the result stays in place. The unit then lowers `in_ready` until that result is taken. When `out_ready` stays high, the unit takes back-to-back requests with no bubble, and results leave in the order their requests arrived.

Top module: `vsig_unit`

## Requirements
- R1: `in_ctl[4]` picks the family: 0 selects the message-expansion sigmas and 1 selects the round-compression sigmas. `in_ctl[3:0]` is the per-lane variant mask, where 0 picks sigma0 and 1 picks sigma1.
- R2: In narrow mode (`in_wide`=0) with family 0, a lane with mask bit 0 yields rotr(x,7)^rotr(x,18)^(x>>3). A lane with mask bit 1 yields rotr(x,17)^rotr(x,19)^(x>>10).
- R3: In narrow mode with family 1, a lane with mask bit 0 yields rotr(x,2)^rotr(x,13)^rotr(x,22). A lane with mask bit 1 yields rotr(x,6)^rotr(x,11)^rotr(x,25).
- R4: In wide mode (`in_wide`=1) with family 0, a lane with mask bit 0 yields rotr(x,1)^rotr(x,8)^(x>>7). A lane with mask bit 1 yields rotr(x,19)^rotr(x,61)^(x>>6).
- R5: In wide mode with family 1, a lane with mask bit 0 yields rotr(x,28)^rotr(x,34)^rotr(x,39). A lane with mask bit 1 yields rotr(x,14)^rotr(x,18)^rotr(x,41).
- R6: In narrow mode, lane i occupies bits [127-32i : 96-32i], so lane 0 is the most significant word. Lane i is steered by `in_ctl[3-i]`.
- R7: In wide mode, lane 0 occupies bits [127:64] and is steered by `in_ctl[3]`. Lane 1 occupies bits [63:0] and is steered by `in_ctl[1]`. Bits `in_ctl[2]` and `in_ctl[0]` have no effect on the result.
- R8: A synchronous active-high `rst` clears `out_valid`. A request accepted on a clock edge (`in_valid` and `in_ready` both high) makes `out_valid` high with its result after that same edge.
- R9: `in_ready` equals `!out_valid || out_ready`. With `out_ready` held high, the unit accepts one request per cycle, and each accepted request produces exactly one result, in order.
- R10: While `out_valid` is high and `out_ready` is low, `out_vec` and `out_valid` hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_vec | input | 128 | Source vector, lane 0 at the most significant end |
| in_wide | input | 1 | 0: four 32-bit lanes, 1: two 64-bit lanes |
| in_ctl | input | 5 | Bit 4 family select, bits 3..0 variant mask |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_vec | output | 128 | Sigma result vector |

## Verification
The only state is the output register and its valid flag, so any internal fault appears at the ports within one handshake. A stuck or miscleared valid flag shows up as a missing, duplicated or reordered result. The bench catches this at the next output handshake, because its in-order queue of expected vectors falls out of step. A miswired mask route or a wrong rotation constant corrupts the lane concerned on the very next result for that mode and family. This is why the bench sweeps all 32 control values in both modes, and labels each mismatch with the mode and family involved.

// File: rtl/vsig_pkg.sv
package vsig_pkg;
  localparam int VEC_W   = 128;
  localparam int CTL_W   = 5;
  localparam int NARROW  = 32;
  localparam int WIDE    = 64;
  localparam int N_LANES = VEC_W / NARROW;
  localparam int W_LANES = VEC_W / WIDE;

  typedef enum logic {
    FAM_EXPAND = 1'b0,
    FAM_ROUND  = 1'b1
  } fam_e;

  // Rotation/shift distance for term k of the function picked by
  // (lane width, family, variant). For the expansion family, term 2 is a
  // logical shift; every other term is a right rotation.
  function automatic int amt(input bit is64, input bit fam, input bit vsel, input int k);
    int t0, t1, t2;
    case ({is64, fam, vsel})
      3'b000:  begin t0 = 7;  t1 = 18; t2 = 3;  end
      3'b001:  begin t0 = 17; t1 = 19; t2 = 10; end
      3'b010:  begin t0 = 2;  t1 = 13; t2 = 22; end
      3'b011:  begin t0 = 6;  t1 = 11; t2 = 25; end
      3'b100:  begin t0 = 1;  t1 = 8;  t2 = 7;  end
      3'b101:  begin t0 = 19; t1 = 61; t2 = 6;  end
      3'b110:  begin t0 = 28; t1 = 34; t2 = 39; end
      default: begin t0 = 14; t1 = 18; t2 = 41; end
    endcase
    if (k == 0) return t0;
    if (k == 1) return t1;
    return t2;
  endfunction
endpackage

// File: rtl/vsig_lane.sv
module vsig_lane #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic         fam,
  input  logic         pick,
  output logic [W-1:0] y
);
  localparam bit IS64 = (W == 64);

  logic [2*W-1:0]      dbl;
  logic [3:0][W-1:0]   cand;

  assign dbl = {x, x};

  // Candidate index = {family, variant}; all four built in parallel.
  for (genvar c = 0; c < 4; c++) begin : g_cand
    localparam bit CF = (c >= 2);
    localparam bit CV = ((c % 2) == 1);
    localparam int A0 = vsig_pkg::amt(IS64, CF, CV, 0);
    localparam int A1 = vsig_pkg::amt(IS64, CF, CV, 1);
    localparam int A2 = vsig_pkg::amt(IS64, CF, CV, 2);
    logic [W-1:0] t2;
    if (CF) begin : g_rot
      assign t2 = dbl[A2 +: W];
    end else begin : g_shr
      assign t2 = x >> A2;
    end
    assign cand[c] = dbl[A0 +: W] ^ dbl[A1 +: W] ^ t2;
  end

  assign y = cand[{fam, pick}];
endmodule

// File: rtl/vsig_route.sv
module vsig_route #(
  parameter int NL = 4
) (
  input  logic [NL-1:0]   mask,
  output logic [NL-1:0]   pick_n,
  output logic [NL/2-1:0] pick_w
);
  // Narrow lane i (0 = most significant) reads mask bit NL-1-i.
  for (genvar i = 0; i < NL; i++) begin : g_n
    assign pick_n[i] = mask[NL-1-i];
  end
  // Wide lane j reads every other mask bit, starting from the top.
  for (genvar j = 0; j < NL/2; j++) begin : g_w
    assign pick_w[j] = mask[NL-1-2*j];
  end
endmodule

// File: rtl/vsig_datapath.sv
module vsig_datapath
  import vsig_pkg::*;
(
  input  logic [VEC_W-1:0] vec,
  input  logic             wide,
  input  logic [CTL_W-1:0] ctl,
  output logic [VEC_W-1:0] res
);
  logic [N_LANES-1:0] pick_n;
  logic [W_LANES-1:0] pick_w;
  logic [VEC_W-1:0]   res_n;
  logic [VEC_W-1:0]   res_w;
  logic               fam;

  assign fam = ctl[CTL_W-1];

  vsig_route #(.NL(N_LANES)) u_route (
    .mask   (ctl[N_LANES-1:0]),
    .pick_n (pick_n),
    .pick_w (pick_w)
  );

  for (genvar i = 0; i < N_LANES; i++) begin : g_nl
    vsig_lane #(.W(NARROW)) u_lane (
      .x    (vec[VEC_W-1-NARROW*i -: NARROW]),
      .fam  (fam),
      .pick (pick_n[i]),
      .y    (res_n[VEC_W-1-NARROW*i -: NARROW])
    );
  end

  for (genvar j = 0; j < W_LANES; j++) begin : g_wl
    vsig_lane #(.W(WIDE)) u_lane (
      .x    (vec[VEC_W-1-WIDE*j -: WIDE]),
      .fam  (fam),
      .pick (pick_w[j]),
      .y    (res_w[VEC_W-1-WIDE*j -: WIDE])
    );
  end

  assign res = wide ? res_w : res_n;
endmodule

// File: rtl/vsig_outreg.sv
module vsig_outreg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  output logic         d_ready,
  input  logic [W-1:0] d,
  output logic         q_valid,
  input  logic         q_ready,
  output logic [W-1:0] q
);
  logic load;

  assign d_ready = !q_valid || q_ready;
  assign load    = d_valid && d_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      if (load) begin
        q_valid <= 1'b1;
        q       <= d;
      end else if (q_ready) begin
        q_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vsig_unit.sv
module vsig_unit
  import vsig_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_vec,
  input  logic             in_wide,
  input  logic [CTL_W-1:0] in_ctl,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_vec
);
  logic [VEC_W-1:0] res;

  vsig_datapath u_dp (
    .vec  (in_vec),
    .wide (in_wide),
    .ctl  (in_ctl),
    .res  (res)
  );

  vsig_outreg #(.W(VEC_W)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d_ready (in_ready),
    .d       (res),
    .q_valid (out_valid),
    .q_ready (out_ready),
    .q       (out_vec)
  );
endmodule

// File: rtl/vsig_unit_chk.sv
module vsig_unit_chk
  import vsig_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [VEC_W-1:0] in_vec,
  input logic [CTL_W-1:0] in_ctl,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_vec
);
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid); // R8

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R9

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid); // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_vec)); // R10

  AST_ZERO_MAPS_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (in_vec == '0) |=> out_vec == '0); // R1

  AST_ROUND_ONES: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_ctl[CTL_W-1] && (in_vec == '1) |=> out_vec == '1); // R3
endmodule

bind vsig_unit vsig_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_vec    (in_vec),
  .in_ctl    (in_ctl),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_vec   (out_vec)
);

// File: tb/vsig_unit_tb.sv
`timescale 1ns/1ps
module vsig_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_vec = '0;
  logic         in_wide = 1'b0;
  logic [4:0]   in_ctl = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_vec;

  int checks = 0;
  int fails  = 0;
  bit bp_en  = 1'b0;
  bit mon_en = 1'b0;

  logic [127:0] exp_q[$];
  string        tag_q[$];

  always #2.5 clk = ~clk;

  vsig_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_vec(in_vec), .in_wide(in_wide), .in_ctl(in_ctl),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec)
  );

  // Reference model
  function automatic logic [31:0] r32(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic logic [63:0] r64(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction
  function automatic logic [31:0] s32(input logic [31:0] x, input bit st, input bit sel);
    if (!st) return sel ? (r32(x,17) ^ r32(x,19) ^ (x >> 10)) : (r32(x,7) ^ r32(x,18) ^ (x >> 3));
    return sel ? (r32(x,6) ^ r32(x,11) ^ r32(x,25)) : (r32(x,2) ^ r32(x,13) ^ r32(x,22));
  endfunction
  function automatic logic [63:0] s64(input logic [63:0] x, input bit st, input bit sel);
    if (!st) return sel ? (r64(x,19) ^ r64(x,61) ^ (x >> 6)) : (r64(x,1) ^ r64(x,8) ^ (x >> 7));
    return sel ? (r64(x,14) ^ r64(x,18) ^ r64(x,41)) : (r64(x,28) ^ r64(x,34) ^ r64(x,39));
  endfunction
  function automatic logic [127:0] ref_vec(input logic [127:0] v, input bit w, input logic [4:0] c);
    logic [127:0] r;
    r = '0;
    if (w) begin
      for (int i = 0; i < 2; i++) r[127-64*i -: 64] = s64(v[127-64*i -: 64], c[4], c[3-2*i]);
    end else begin
      for (int i = 0; i < 4; i++) r[127-32*i -: 32] = s32(v[127-32*i -: 32], c[4], c[3-i]);
    end
    return r;
  endfunction
  function automatic string tag_of(input bit w, input logic [4:0] c);
    if (w) return c[4] ? "R1 R5 R7" : "R1 R4 R7";
    return c[4] ? "R1 R3 R6" : "R1 R2 R6";
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Driver: called at a falling edge; returns at the falling edge after acceptance.
  task automatic send(input logic [127:0] v, input bit w, input logic [4:0] c);
    bit done;
    done = 1'b0;
    in_valid = 1'b1; in_vec = v; in_wide = w; in_ctl = c;
    while (!done) begin
      #1;
      if (in_ready) begin
        exp_q.push_back(ref_vec(v, w, c));
        tag_q.push_back(tag_of(w, c));
        done = 1'b1;
      end
      @(negedge clk);
    end
    checks++;
    if (out_valid !== 1'b1) begin
      fails++;
      $display("FAIL R8 out_valid after accept: got %b expected 1", out_valid);
    end
  endtask

  // Monitor / scoreboard with optional back-pressure
  logic [127:0] held_vec;
  bit           held = 1'b0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (held) begin
        checks++;
        if (out_valid !== 1'b1 || out_vec !== held_vec) begin
          fails++;
          $display("FAIL R10 held output: got v=%b %h expected v=1 %h", out_valid, out_vec, held_vec);
        end
      end
      out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
      held = out_valid && !out_ready;
      held_vec = out_vec;
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected result: got %h expected none", out_vec);
        end else begin
          logic [127:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_vec !== e) begin
            fails++;
            $display("FAIL %s result: got %h expected %h", t, out_vec, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R8 reset state: got valid=%b ready=%b expected 0 1", out_valid, in_ready);
    end
    rst = 1'b0;
    @(negedge clk);
    mon_en = 1'b1;
    for (int ph = 0; ph < 2; ph++) begin
      bp_en = (ph == 1);
      for (int w = 0; w < 2; w++) begin
        for (int c = 0; c < 32; c++) begin
          for (int k = 0; k < 3; k++) begin
            logic [127:0] v;
            if (k == 2) v = 128'h1 << (c * 4 + w);
            else v = {$urandom, $urandom, $urandom, $urandom};
            send(v, w[0], c[4:0]);
          end
        end
      end
      // directed extremes in each mode and family
      send('1, 1'b0, 5'h1F); send('1, 1'b1, 5'h10);
      send('0, 1'b1, 5'h0A); send({4{32'h8000_0001}}, 1'b0, 5'h05);
    end
    in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    summary();
    $finish;
  end
endmodule